// File: doc/BRIEF.md
# External Clock Input Conditioning

This block turns activity on external pins into counting pulses for a timer. It offers two sources. The first source takes one of two channel pins. Each channel pin has its own digital filter, and each has its own choice of active edge. A trigger select then picks which channel counts. The second source is a dedicated trigger pin. It passes in order through optional inversion, an edge prescaler that divides by 1, 2, 4 or 8, and a digital filter.

All pins are first brought into the clock domain by a two-flop synchroniser. The filters do not sample on every cycle. They take samples on a strobe that is the internal clock divided by a selectable ratio. The result is a one-cycle clock-enable pulse, `cnt_tick`, that feeds the counter's own prescaler. Because of the synchroniser and the filter, the dedicated pin should toggle no faster than a quarter of the internal clock once it has been prescaled.

Top module: `ext_clk_cond`

## Requirements
- R1: While `rst_n` is low, `cnt_tick` is 0.
- R2: With `ext_mode_en`=0 and `slave_mode`=3'd7, `trig_sel`=3'd1 counts the channel 1 path and `trig_sel`=3'd2 counts the channel 2 path. Activity on the unselected channel pin produces no pulse.
- R3: On a channel path, `chN_fall`=0 makes the rising edge of the filtered pin active and `chN_fall`=1 makes the falling edge active. A pin held at its new level gives no further pulse, so a complete high pulse yields exactly one tick under either setting.
- R4: `etr_inv`=1 inverts the dedicated pin before the prescaler, which makes its falling pin edges the active ones. `etr_inv`=0 makes its rising edges active.
- R5: Let P be 1, 2, 4 or 8 for `etr_psc` = 0, 1, 2 or 3. After reset, K active edges on the dedicated pin give K ticks when P=1. For P≥2 they give (2K+P)/(2P) ticks, using integer division, which is one tick per P edges with the first at edge P/2.
- R6: The filter sampling strobe occurs every D clock cycles. D is 1, 2, 4 or 4 for `smp_div` = 0, 1, 2 or 3.
- R7: A filter setting of 0 passes its input straight through. A setting N≥1 changes the filter output only on a strobe, and only after N+1 consecutive strobe samples have shown the new level. A pulse of at most N·D cycles is rejected. A pulse of at least (N+2)·D cycles is passed.
- R8: `ext_mode_en`=1 selects the dedicated pin path, whatever the channel selection says.
- R9: Every `cnt_tick` pulse lasts exactly one cycle. Two ticks are never on consecutive cycles.
- R10: While `cnt_en`=0, no tick is produced and the dedicated-path prescaler does not advance.
- R11: With `ext_mode_en`=0, a `slave_mode` other than 3'd7, or a `trig_sel` other than 1 or 2, selects no source, and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter enable; gates ticks and prescaler |
| ext_mode_en | input | 1 | Select dedicated pin path |
| slave_mode | input | 3 | 3'd7 selects the channel trigger path |
| trig_sel | input | 3 | 1 = channel 1, 2 = channel 2 |
| ch1_in | input | 1 | Channel 1 pin |
| ch2_in | input | 1 | Channel 2 pin |
| ch1_fall | input | 1 | Channel 1 active edge: 1 = falling |
| ch2_fall | input | 1 | Channel 2 active edge: 1 = falling |
| ch1_flt | input | FLT_W | Channel 1 filter length |
| ch2_flt | input | FLT_W | Channel 2 filter length |
| etr_in | input | 1 | Dedicated trigger pin |
| etr_inv | input | 1 | Invert dedicated pin |
| etr_psc | input | 2 | Dedicated pin edge prescaler |
| etr_flt | input | FLT_W | Dedicated pin filter length |
| smp_div | input | 2 | Filter sampling divider |
| cnt_tick | output | 1 | One-cycle counting pulse |

## Verification
A wrong internal state shows up at `cnt_tick` in one of three ways. The pulse count can differ from the expected count, a pulse can be doubled, or a pulse can be missing. A prescaler that is off by one phase moves the first tick by P/2 edges, so the count after a short burst of edges exposes it. A filter counter that fails to clear lets a glitch through as a stray tick. A filter counter that clears too eagerly swallows a legal pulse. Either fault is visible within about (N+2)·D cycles plus the three-cycle synchroniser and edge latency after the pin changes.

// File: rtl/ext_clk_cond.sv
module ext_clk_cond #(
  parameter int FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             ext_mode_en,
  input  logic [2:0]       slave_mode,
  input  logic [2:0]       trig_sel,
  input  logic             ch1_in,
  input  logic             ch2_in,
  input  logic             ch1_fall,
  input  logic             ch2_fall,
  input  logic [FLT_W-1:0] ch1_flt,
  input  logic [FLT_W-1:0] ch2_flt,
  input  logic             etr_in,
  input  logic             etr_inv,
  input  logic [1:0]       etr_psc,
  input  logic [FLT_W-1:0] etr_flt,
  input  logic [1:0]       smp_div,
  output logic             cnt_tick
);
  localparam int NSRC = 3;

  logic [NSRC-1:0] s1, s2;
  logic            etr_p, etr_p_q;
  logic [2:0]      psc_cnt;
  logic            psc_out;
  logic [1:0]      dcnt;
  logic            smp_stb;
  logic [NSRC-1:0] fin, fo, fo_q, rise, fall;
  logic [FLT_W-1:0] fn [NSRC];
  logic [1:0]      ch_edge;
  logic            sel_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {etr_in, ch2_in, ch1_in};
      s2 <= s1;
    end

  assign etr_p = s2[2] ^ etr_inv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      etr_p_q <= 1'b0;
      psc_cnt <= '0;
    end else begin
      etr_p_q <= etr_p;
      if (cnt_en && etr_p && !etr_p_q) psc_cnt <= psc_cnt + 3'd1;
    end

  assign psc_out = (etr_psc == 2'd0) ? etr_p : psc_cnt[etr_psc - 2'd1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else        dcnt <= dcnt + 2'd1;

  assign smp_stb = (smp_div == 2'd0) ? 1'b1 :
                   (smp_div == 2'd1) ? dcnt[0] : &dcnt;

  assign fin   = {psc_out, s2[1], s2[0]};
  assign fn[0] = ch1_flt;
  assign fn[1] = ch2_flt;
  assign fn[2] = etr_flt;

  for (genvar g = 0; g < NSRC; g++) begin : g_flt
    logic [FLT_W-1:0] fc;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        fo[g] <= 1'b0;
        fc    <= '0;
      end else if (fn[g] == '0) begin
        fo[g] <= fin[g];
        fc    <= '0;
      end else if (smp_stb) begin
        if (fin[g] == fo[g]) fc <= '0;
        else if (fc >= fn[g]) begin
          fo[g] <= fin[g];
          fc    <= '0;
        end else fc <= fc + 1'b1;
      end

    AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fn[g] != '0 && !smp_stb) |=> $stable(fo[g])); // R7
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fo_q <= '0;
    else        fo_q <= fo;

  assign rise    = fo & ~fo_q;
  assign fall    = ~fo & fo_q;
  assign ch_edge = {ch2_fall ? fall[1] : rise[1], ch1_fall ? fall[0] : rise[0]};

  always_comb begin
    sel_edge = 1'b0;
    if (ext_mode_en) sel_edge = rise[2];
    else if (slave_mode == 3'd7) begin
      if (trig_sel == 3'd1)      sel_edge = ch_edge[0];
      else if (trig_sel == 3'd2) sel_edge = ch_edge[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_tick <= 1'b0;
    else        cnt_tick <= cnt_en & sel_edge;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |=> !cnt_tick); // R9
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> !cnt_tick); // R10
  AST_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode_en && (slave_mode != 3'd7 || (trig_sel != 3'd1 && trig_sel != 3'd2)))
      |=> !cnt_tick); // R11
  AST_PSC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(psc_cnt)); // R10
endmodule

// File: tb/test_ext_clk_cond.sv
`timescale 1ns/1ps
module test_ext_clk_cond;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, ext_mode_en = 1'b0;
  logic [2:0] slave_mode = '0, trig_sel = '0;
  logic ch1_in = 1'b0, ch2_in = 1'b0, ch1_fall = 1'b0, ch2_fall = 1'b0;
  logic [3:0] ch1_flt = '0, ch2_flt = '0, etr_flt = '0;
  logic etr_in = 1'b0, etr_inv = 1'b0;
  logic [1:0] etr_psc = '0, smp_div = '0;
  logic cnt_tick;

  int n_vec = 0, n_bad = 0;
  int tick_cnt = 0, dbl = 0;
  logic prev_tick = 1'b0;

  always #10 clk = ~clk;

  ext_clk_cond i_ext_clk_cond (.*);

  always @(negedge clk) begin
    if (rst_n && cnt_tick) tick_cnt++;
    if (rst_n && cnt_tick && prev_tick) dbl++;
    prev_tick = rst_n && cnt_tick;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic int exp_ticks(input int k, input logic [1:0] psc);
    int p = 1 << psc;
    return (p == 1) ? k : (2 * k + p) / (2 * p);
  endfunction

  task automatic restart();
    @(negedge clk);
    cnt_en = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    cnt_en = 1'b1;
  endtask

  task automatic set_pin(input int which, input logic v);
    case (which)
      0: ch1_in = v;
      1: ch2_in = v;
      default: etr_in = v;
    endcase
  endtask

  task automatic pulses(input int which, input logic idle, input int k, input int h, input bit noise);
    for (int i = 0; i < k; i++) begin
      set_pin(which, ~idle);
      if (noise) begin
        if (which != 0) ch1_in = 1'($urandom);
        if (which != 1) ch2_in = 1'($urandom);
      end
      repeat (h) @(negedge clk);
      set_pin(which, idle);
      repeat (h) @(negedge clk);
    end
    if (noise) begin
      if (which != 0) ch1_in = 1'b0;
      if (which != 1) ch2_in = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int start, k, h, path, flt;
    logic [1:0] sd, ps;
    void'($urandom(32'd2718));

    repeat (2) @(negedge clk);
    chk("R1 tick low in reset", int'(cnt_tick), 0);

    // R2: channel 2 selected, channel 1 toggles only
    slave_mode = 3'd7; trig_sel = 3'd2;
    restart();
    start = tick_cnt;
    pulses(0, 1'b0, 5, 6, 1'b0);
    repeat (10) @(negedge clk);
    chk("R2 unselected channel ignored", tick_cnt - start, 0);
    pulses(1, 1'b0, 4, 6, 1'b0);
    repeat (10) @(negedge clk);
    chk("R2 selected channel counts", tick_cnt - start, 4);

    // R3: falling edge active, held-high gives nothing
    trig_sel = 3'd1; ch1_fall = 1'b1;
    restart();
    start = tick_cnt;
    ch1_in = 1'b1;
    repeat (20) @(negedge clk);
    chk("R3 rising ignored in falling mode", tick_cnt - start, 0);
    ch1_in = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 falling edge counts", tick_cnt - start, 1);
    ch1_fall = 1'b0;

    // R7: glitch reject vs pass, N=3, D=2
    ch1_flt = 4'd3; smp_div = 2'd1;
    restart();
    start = tick_cnt;
    pulses(0, 1'b0, 1, 6, 1'b0);
    repeat (20) @(negedge clk);
    chk("R7 short pulse rejected", tick_cnt - start, 0);
    pulses(0, 1'b0, 1, 10, 1'b0);
    repeat (20) @(negedge clk);
    chk("R7 long pulse passed", tick_cnt - start, 1);

    // R6: divider 4 needs longer pulse for N=1
    ch1_flt = 4'd1; smp_div = 2'd2;
    restart();
    start = tick_cnt;
    pulses(0, 1'b0, 1, 4, 1'b0);
    repeat (20) @(negedge clk);
    chk("R6 D=4 rejects 4-cycle pulse", tick_cnt - start, 0);
    pulses(0, 1'b0, 1, 12, 1'b0);
    repeat (20) @(negedge clk);
    chk("R6 D=4 passes 12-cycle pulse", tick_cnt - start, 1);

    // R7: unfiltered passes a one-cycle pulse
    ch1_flt = 4'd0; smp_div = 2'd0;
    restart();
    start = tick_cnt;
    pulses(0, 1'b0, 1, 1, 1'b0);
    repeat (10) @(negedge clk);
    chk("R7 zero setting passes 1-cycle pulse", tick_cnt - start, 1);

    // R10: disabled
    restart();
    cnt_en = 1'b0;
    start = tick_cnt;
    pulses(0, 1'b0, 5, 5, 1'b0);
    repeat (10) @(negedge clk);
    chk("R10 disabled no ticks", tick_cnt - start, 0);

    // R10: prescaler frozen while disabled, P=2
    ext_mode_en = 1'b1; etr_psc = 2'd1;
    restart();
    cnt_en = 1'b0;
    pulses(2, 1'b0, 3, 5, 1'b0);
    cnt_en = 1'b1;
    start = tick_cnt;
    pulses(2, 1'b0, 1, 5, 1'b0);
    repeat (10) @(negedge clk);
    chk("R10 prescaler held while disabled", tick_cnt - start, 1);
    etr_psc = 2'd0;

    // R11: no source
    ext_mode_en = 1'b0; slave_mode = 3'd0; trig_sel = 3'd1;
    restart();
    start = tick_cnt;
    pulses(0, 1'b0, 4, 5, 1'b0);
    pulses(2, 1'b0, 4, 5, 1'b0);
    repeat (10) @(negedge clk);
    chk("R11 no source selected", tick_cnt - start, 0);
    slave_mode = 3'd7; trig_sel = 3'd4;
    pulses(0, 1'b0, 3, 5, 1'b0);
    repeat (10) @(negedge clk);
    chk("R11 unused trigger select", tick_cnt - start, 0);

    // R4: inverted dedicated pin
    ext_mode_en = 1'b1; etr_inv = 1'b1; etr_in = 1'b1;
    restart();
    start = tick_cnt;
    etr_in = 1'b0;
    repeat (10) @(negedge clk);
    chk("R4 inverted pin falling edge counts", tick_cnt - start, 1);
    etr_in = 1'b1;
    repeat (10) @(negedge clk);
    chk("R4 inverted pin rising ignored", tick_cnt - start, 1);

    // Random trials: R2 R4 R5 R6 R7 R8
    for (int t = 0; t < 30; t++) begin
      path = int'($urandom % 2);
      sd   = 2'($urandom);
      flt  = int'($urandom % 16);
      ps   = 2'($urandom);
      k    = 1 + int'($urandom % 10);
      h    = (flt + 2) * div_of(sd) + 4;
      smp_div = sd;
      ch1_flt = '0; ch2_flt = '0; etr_flt = '0;
      ch1_in = 1'b0; ch2_in = 1'b0;
      slave_mode = 3'd7;
      if (path == 1) begin
        ext_mode_en = 1'b1;
        trig_sel = 3'(1 + $urandom % 2);
        etr_inv  = 1'($urandom);
        etr_in   = etr_inv;
        etr_psc  = ps;
        etr_flt  = 4'(flt);
        restart();
        start = tick_cnt;
        pulses(2, etr_inv, k, h, 1'b1);
        repeat (2 * h + 20) @(negedge clk);
        chk("R5 R8 dedicated path count", tick_cnt - start, exp_ticks(k, ps));
      end else begin
        ext_mode_en = 1'b0;
        etr_in = 1'b0;
        trig_sel = 3'(1 + $urandom % 2);
        ch1_fall = 1'($urandom);
        ch2_fall = 1'($urandom);
        if (trig_sel == 3'd1) ch1_flt = 4'(flt); else ch2_flt = 4'(flt);
        restart();
        start = tick_cnt;
        pulses(int'(trig_sel) - 1, 1'b0, k, h, 1'b1);
        repeat (2 * h + 20) @(negedge clk);
        chk("R2 R6 R7 channel path count", tick_cnt - start, k);
      end
    end

    chk("R9 no back-to-back ticks", dbl, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule